// File: doc/BRIEF.md
# Multiplexed Display Refresh Controller

This block keeps the segment pattern for each of sixteen display positions in a small internal memory and scans that memory out to a time-multiplexed display. A host processor fills the memory at full clock speed. While its transfer request is held high, the memory address comes from the host address inputs and the host data word is written on every clock edge. While the request is low, a free-running 4-bit scan counter supplies the address.

The scan counter advances once per display step. A step lasts `STEP_TICKS` refresh ticks, and a refresh tick comes every `TICK_DIV` system clocks. The counter value is rotated left by one bit to form the position index. The memory word for that index goes to the segment outputs, and one matching bit of the one-hot position select is driven. As a result the first eight steps light positions 0, 2, 4 … 14 and the next eight light 1, 3 … 15, so neighbouring positions are never driven in consecutive steps. The first tick of every step is a blanking interval in which both output buses are zero. The outputs are also held at zero while a host transfer is under way.

Top module: `disp_scan_ctrl`

## Requirements
- R1: After synchronous reset, `seg_o` and `pos_sel_o` are zero, the scan count is 0, and every memory entry reads as zero until the host writes it.
- R2: While `host_req` is 1, each rising clock edge stores `host_data` into entry `host_addr`, and a later write to the same entry replaces the earlier one. Entry k is the pattern shown when bit k of `pos_sel_o` is set.
- R3: The scan count s starts at 0 and rises by one per step, wrapping after 15. The lit position index is {s[2:0], s[3]}, so the order is 0, 2, 4, …, 14, 1, 3, …, 15.
- R4: `pos_sel_o` never has more than one bit set. When it is not zero, it has exactly the bit named in R3.
- R5: Whenever a position is lit, `seg_o` equals the stored entry for that position, and `seg_o` is zero whenever `pos_sel_o` is zero.
- R6: A refresh tick occurs every `TICK_DIV` clocks and a step spans `STEP_TICKS` ticks. During the first tick of each step both outputs are zero, so a position stays lit for `TICK_DIV*(STEP_TICKS-1)` clocks and lit intervals start `TICK_DIV*STEP_TICKS` clocks apart.
- R7: If `host_req` is 1 before a clock edge, both outputs are zero after the following edge. A request therefore blanks the display with a latency of two edges.
- R8: The scan timing keeps running during host transfers. The outputs are registered and reflect the scan state and `host_req` as they stood two clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host transfer request; writes memory while high |
| host_addr | input | 4 | Entry index for host writes |
| host_data | input | SEG_W | Segment pattern to store |
| seg_o | output | SEG_W | Segment drive for the lit position |
| pos_sel_o | output | 16 | One-hot position (anode) select |

## Verification
Three functions can land on the same clock: a host write, the blanking at the first tick of a step, and the lighting of a position. The bench holds `host_req` high in the middle of a lit interval, and also runs a burst of writes that spans a step boundary. A cycle-accurate reference model, computed from the elapsed edge count and the host history, gives the expected value of both buses after every edge. A directed check confirms that the display is still lit one edge after the request and dark after the second. It also checks that the step order continues unchanged once the request ends.

// File: rtl/dscan_pkg.sv
package dscan_pkg;
  localparam int SCAN_W = 4;
  localparam int NPOS   = 1 << SCAN_W;

  // rotate scan count left by one bit to get the lit position index
  function automatic logic [SCAN_W-1:0] scan_to_pos(input logic [SCAN_W-1:0] s);
    return {s[SCAN_W-2:0], s[SCAN_W-1]};
  endfunction
endpackage

// File: rtl/dscan_tick.sv
module dscan_tick #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV > 1) begin : g_div
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else if (cnt_q == CW'(TICK_DIV - 1)) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == CW'(TICK_DIV - 1));

      // spacing of ticks (R6)
      assert_tick_spaced_R6: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end else begin : g_nodiv
      assign tick_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/dscan_seq.sv
module dscan_seq
  import dscan_pkg::*;
#(
  parameter int STEP_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  output logic [SCAN_W-1:0] scan_o,
  output logic              blank_o
);
  localparam int PW = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
  localparam logic [PW-1:0] LAST = PW'(STEP_TICKS - 1);

  logic [PW-1:0]     phase_q;
  logic [SCAN_W-1:0] scan_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      scan_q  <= '0;
    end else if (tick_i) begin
      if (phase_q == LAST) begin
        phase_q <= '0;
        scan_q  <= scan_q + 1'b1;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign scan_o  = scan_q;
  assign blank_o = (phase_q == '0);

  // scan count only ever steps by one (R3)
  assert_scan_step_R3: assert property (@(posedge clk) disable iff (rst)
    (scan_q != $past(scan_q)) |-> (scan_q == SCAN_W'($past(scan_q) + 1'b1)));

  // a new step always opens with the blanking phase (R6)
  assert_step_opens_blank_R6: assert property (@(posedge clk) disable iff (rst)
    (tick_i && phase_q == LAST) |=> blank_o);
endmodule

// File: rtl/dscan_ram.sv
module dscan_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] valid_q;
  logic [W-1:0]     rd_q;
  logic             rd_vld_q;

  // plain array with synchronous read, read-first: maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q <= mem[raddr];
  end

  // per-entry written flags give a zero image after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      rd_vld_q <= 1'b0;
    end else begin
      if (we) valid_q[waddr] <= 1'b1;
      rd_vld_q <= valid_q[raddr];
    end
  end

  assign rdata = rd_vld_q ? rd_q : '0;
endmodule

// File: rtl/disp_scan_ctrl.sv
module disp_scan_ctrl
  import dscan_pkg::*;
#(
  parameter int SEG_W      = 8,
  parameter int TICK_DIV   = 1000,
  parameter int STEP_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic [SCAN_W-1:0] host_addr,
  input  logic [SEG_W-1:0]  host_data,
  output logic [SEG_W-1:0]  seg_o,
  output logic [NPOS-1:0]   pos_sel_o
);
  logic              tick;
  logic [SCAN_W-1:0] scan;
  logic              phase_blank;
  logic [SCAN_W-1:0] scan_pos;
  logic [SCAN_W-1:0] rd_addr;
  logic [SEG_W-1:0]  rd_data;

  dscan_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  dscan_seq #(.STEP_TICKS(STEP_TICKS)) u_seq (
    .clk(clk), .rst(rst), .tick_i(tick), .scan_o(scan), .blank_o(phase_blank)
  );

  assign scan_pos = scan_to_pos(scan);
  assign rd_addr  = host_req ? host_addr : scan_pos;

  dscan_ram #(.W(SEG_W), .DEPTH(NPOS)) u_ram (
    .clk(clk), .rst(rst),
    .we(host_req), .waddr(host_addr), .wdata(host_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  // stage 1: align control with the synchronous memory read
  logic              s1_blank;
  logic [SCAN_W-1:0] s1_pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_blank <= 1'b1;
      s1_pos   <= '0;
    end else begin
      s1_blank <= phase_blank | host_req;
      s1_pos   <= scan_pos;
    end
  end

  logic [NPOS-1:0] pos_dec;
  for (genvar i = 0; i < NPOS; i++) begin : g_dec
    assign pos_dec[i] = (s1_pos == SCAN_W'(i));
  end

  // stage 2: registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      seg_o     <= '0;
      pos_sel_o <= '0;
    end else if (s1_blank) begin
      seg_o     <= '0;
      pos_sel_o <= '0;
    end else begin
      seg_o     <= rd_data;
      pos_sel_o <= pos_dec;
    end
  end

  assert_pos_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pos_sel_o));

  assert_seg_only_lit_R5: assert property (@(posedge clk) disable iff (rst)
    (seg_o != '0) |-> (pos_sel_o != '0));

  assert_host_blank_R7: assert property (@(posedge clk) disable iff (rst)
    host_req |-> ##2 (pos_sel_o == '0 && seg_o == '0));

  assert_phase_blank_R6: assert property (@(posedge clk) disable iff (rst)
    phase_blank |-> ##2 (pos_sel_o == '0));
endmodule

// File: tb/tb_disp_scan_ctrl.sv
module tb_disp_scan_ctrl;
  localparam int SEG_W = 8;
  localparam int D     = 3;
  localparam int N     = 4;
  localparam int STEP  = D * N;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             host_req = 1'b0;
  logic [3:0]       host_addr = '0;
  logic [SEG_W-1:0] host_data = '0;
  logic [SEG_W-1:0] seg_o;
  logic [15:0]      pos_sel_o;

  always #2 clk = ~clk;

  disp_scan_ctrl #(.SEG_W(SEG_W), .TICK_DIV(D), .STEP_TICKS(N)) dut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_addr(host_addr),
    .host_data(host_data), .seg_o(seg_o), .pos_sel_o(pos_sel_o)
  );

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  logic cmp_en = 1'b0;

  // write vectors: {addr, data}
  localparam logic [11:0] WR_VEC [16] = '{
    12'h0_11, 12'h1_22, 12'h2_33, 12'h3_44, 12'h4_55, 12'h5_66, 12'h6_77, 12'h7_88,
    12'h8_99, 12'h9_AA, 12'hA_BB, 12'hB_CC, 12'hC_DD, 12'hD_EE, 12'hE_F1, 12'hF_7E
  };

  // reference model from the requirements
  function automatic logic [3:0] rot(input logic [3:0] s);
    return {s[2:0], s[3]};
  endfunction

  int unsigned nedge;
  logic [SEG_W-1:0] mem_m [16];
  logic [SEG_W-1:0] e_seg1, e_seg2;
  logic [15:0]      e_pos1, e_pos2;
  logic             e_host1, e_host2;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      nedge <= 0;
      e_seg1 <= '0; e_seg2 <= '0; e_pos1 <= '0; e_pos2 <= '0;
      e_host1 <= 1'b0; e_host2 <= 1'b0;
      for (int i = 0; i < 16; i++) mem_m[i] <= '0;
    end else begin
      logic [3:0] p;
      logic       bl;
      p  = rot(4'((nedge / STEP) % 16));
      bl = (((nedge / D) % N) == 0) || host_req;
      e_seg1  <= bl ? '0 : mem_m[p];
      e_pos1  <= bl ? '0 : (16'h1 << p);
      e_host1 <= host_req;
      e_seg2  <= e_seg1;
      e_pos2  <= e_pos1;
      e_host2 <= e_host1;
      if (host_req) mem_m[host_addr] <= host_data;
      nedge <= nedge + 1;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      n_run++;
      if (seg_o !== e_seg2 || pos_sel_o !== e_pos2) begin
        n_fail++;
        if (e_host2)
          $display("FAIL R7 host blank: seg=%h pos=%h exp seg=%h pos=%h", seg_o, pos_sel_o, e_seg2, e_pos2);
        else if (e_pos2 == '0)
          $display("FAIL R6 step blank: seg=%h pos=%h exp seg=%h pos=%h", seg_o, pos_sel_o, e_seg2, e_pos2);
        else if (pos_sel_o !== e_pos2)
          $display("FAIL R4 position: pos=%h exp %h (R8 timing)", pos_sel_o, e_pos2);
        else
          $display("FAIL R5 segments: seg=%h exp %h", seg_o, e_seg2);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_pos(input logic [15:0] want, output int at);
    int k = 0;
    while (pos_sel_o !== want && k < 1000) begin
      @(negedge clk); k++;
    end
    at = cyc;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; host_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  bit done = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int t0, t1, nz, lit;
    do_reset();
    // R1: reset state on the outputs
    check("R1 seg after reset", 32'(seg_o), 0);
    check("R1 pos after reset", 32'(pos_sel_o), 0);
    cmp_en = 1'b1;
    // R1: empty memory shows zero for a full frame while positions cycle
    nz = 0;
    for (int i = 0; i < 16 * STEP; i++) begin
      @(negedge clk);
      if (seg_o != '0) nz++;
    end
    check("R1 memory reads zero", 32'(nz), 0);

    // R2: load every entry from the vector table in one burst
    for (int i = 0; i < 16; i++) begin
      host_req  = 1'b1;
      host_addr = WR_VEC[i][11:8];
      host_data = WR_VEC[i][7:0];
      @(negedge clk);
    end
    host_req = 1'b0;

    // R3/R6: order of positions and step timing over a full frame
    wait_pos(16'h0000, t0);
    wait_pos(16'h0001, t0);
    check("R2 entry 0 on position 0", 32'(seg_o), 32'h11);
    lit = 0;
    while (pos_sel_o == 16'h0001) begin @(negedge clk); lit++; end
    check("R6 lit length", 32'(lit), 32'(D * (N - 1)));
    for (int k = 1; k < 16; k++) begin
      logic [3:0] p;
      p = rot(4'(k));
      wait_pos(16'h1 << p, t1);
      check("R3 next position", 32'(pos_sel_o), 32'(16'h1 << p));
      check("R6 step spacing", 32'(t1 - t0), 32'(STEP));
      check("R5 segments of position", 32'(seg_o), 32'(WR_VEC[p][7:0]));
      t0 = t1;
    end

    // R7/R8: request in the middle of a lit interval
    wait_pos(16'h0001, t0);
    @(negedge clk);
    host_req = 1'b1; host_addr = 4'h5; host_data = 8'h5A;
    @(negedge clk);
    check("R8 still lit one edge after request", 32'(pos_sel_o), 32'h0001);
    @(negedge clk);
    check("R7 dark two edges after request", 32'(pos_sel_o), 0);
    check("R7 segments dark", 32'(seg_o), 0);
    // R2: overwrite same entry, last write wins
    host_data = 8'hC3;
    repeat (2 * STEP) @(negedge clk);
    host_req = 1'b0;
    wait_pos(16'h0020, t0);
    check("R2 overwrite shows last value", 32'(seg_o), 32'hC3);
    repeat (16 * STEP) @(negedge clk);

    // R1: reset in mid-run clears outputs and memory image
    cmp_en = 1'b0;
    do_reset();
    check("R1 seg after second reset", 32'(seg_o), 0);
    cmp_en = 1'b1;
    nz = 0;
    for (int i = 0; i < 16 * STEP; i++) begin
      @(negedge clk);
      if (seg_o != '0) nz++;
    end
    check("R1 memory cleared by reset", 32'(nz), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule